// File: doc/BRIEF.md
# UART DMA Request Generator

This block sits between the receive and transmit byte buffers of a serial port and an external DMA engine. It reads the buffer status (the receive occupancy, a receive "trigger level reached" flag, a receive idle-timeout flag and the transmit occupancy) and drives two active-low request lines, one per direction. It also decodes each write of the buffer control byte: it keeps the buffer-enable flag, the DMA policy bit and the two-bit receive trigger selection, and it issues one-cycle clear pulses to the buffers.

Two request policies exist. The per-byte policy asks for receive service whenever any byte is waiting and for transmit service only when the transmit buffer is completely empty. The block policy asks for receive service once the trigger level or the timeout is reached and keeps asking until the receive buffer has drained, while transmit service is requested as long as at least one slot is free. The block policy's receive side is a two-state machine: `RX_IDLE` (not requesting) and `RX_DRAIN` (requesting). The transition `RX_IDLE -> RX_DRAIN` is taken on trigger or timeout with a non-empty buffer; `RX_DRAIN -> RX_IDLE` is taken on an empty buffer; leaving the block policy forces `RX_IDLE`.

Control byte fields: bit 0 enable, bit 1 receive clear, bit 2 transmit clear, bit 3 policy (0 per-byte, 1 block), bits 7:6 receive trigger selection, bits 5:4 unused.

Top module: `uart_dma_req`

## Requirements
- R1: A control write with bit 0 set drives `fifo_en` to 1 and loads the policy from bit 3 and `rx_trig_lvl` from bits 7:6, visible the cycle after the write; bits 5:4 have no effect.
- R2: A control write with bit 0 clear drives `fifo_en` to 0, leaves the stored policy and `rx_trig_lvl` unchanged and produces no clear pulse; while `fifo_en` is 0 the per-byte policy applies whatever the stored policy bit.
- R3: `rx_clr` (and `tx_clr`) is high for exactly the cycle after a write with bits 0 and 1 (bits 0 and 2) set, once per such write; a write with bit 0 set while `fifo_en` is 0 pulses both clears.
- R4: Per-byte policy: `rx_req_n` is 0 when `rx_count` is non-zero and 1 when it is zero.
- R5: Per-byte policy: `tx_req_n` is 0 when `tx_count` is zero and 1 otherwise.
- R6: Block policy: a cycle with `rx_trig_hit` or `rx_timeout` high and `rx_count` non-zero makes `rx_req_n` 0 from the next cycle; it stays 0 (without further trigger) until the cycle after one in which `rx_count` is zero.
- R7: Block policy: a trigger or timeout in a cycle where `rx_count` is zero does not start a receive request.
- R8: Block policy: `tx_req_n` is 0 while `tx_count` is below the depth (16) and 1 when it equals the depth.
- R9: After reset `fifo_en` is 0, the per-byte policy applies, `rx_trig_lvl` is 0 and both clear outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_data | input | 8 | Control byte value |
| rx_count | input | CW (5) | Bytes held in the receive buffer |
| rx_trig_hit | input | 1 | Receive occupancy at or above trigger level |
| rx_timeout | input | 1 | Receive idle timeout reached |
| tx_count | input | CW (5) | Bytes held in the transmit buffer |
| rx_req_n | output | 1 | Receive DMA request, active low |
| tx_req_n | output | 1 | Transmit DMA request, active low |
| rx_clr | output | 1 | One-cycle receive buffer clear |
| tx_clr | output | 1 | One-cycle transmit buffer clear |
| fifo_en | output | 1 | Buffers enabled |
| rx_trig_lvl | output | 2 | Receive trigger selection to the buffer |

## Verification
Two receive-side events can land in one cycle: a trigger or timeout indication and an empty receive buffer, which the bench provokes by raising `rx_trig_hit` with `rx_count` at zero in the block policy and judges by `rx_req_n` staying 1 in the following cycles. A second overlap is a control write that both first-enables the buffers and selects the block policy, where the clear pulses and the policy change must appear together one cycle later. A third is a disabling write landing while the receive side is draining, which must fall back to the per-byte rule at once.

// File: rtl/uart_dma_req_pkg.sv
package uart_dma_req_pkg;
    typedef enum logic {
        RX_IDLE  = 1'b0,
        RX_DRAIN = 1'b1
    } rx_state_e;

    localparam int unsigned CTL_EN_BIT    = 0;
    localparam int unsigned CTL_RXCLR_BIT = 1;
    localparam int unsigned CTL_TXCLR_BIT = 2;
    localparam int unsigned CTL_MODE_BIT  = 3;
    localparam int unsigned CTL_TRIG_LSB  = 6;
endpackage

// File: rtl/uart_dma_ctl_decode.sv
module uart_dma_ctl_decode
    import uart_dma_req_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [7:0] data_i,
    output logic       fifo_en_o,
    output logic       mode_multi_o,
    output logic [1:0] trig_lvl_o,
    output logic       rx_clr_o,
    output logic       tx_clr_o
);
    logic accept;
    logic first_on;

    assign accept   = wr_i && data_i[CTL_EN_BIT];
    assign first_on = accept && !fifo_en_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_en_o    <= 1'b0;
            mode_multi_o <= 1'b0;
            trig_lvl_o   <= 2'd0;
            rx_clr_o     <= 1'b0;
            tx_clr_o     <= 1'b0;
        end else begin
            rx_clr_o <= accept && (data_i[CTL_RXCLR_BIT] || first_on);
            tx_clr_o <= accept && (data_i[CTL_TXCLR_BIT] || first_on);
            if (wr_i) begin
                fifo_en_o <= data_i[CTL_EN_BIT];
                if (data_i[CTL_EN_BIT]) begin
                    mode_multi_o <= data_i[CTL_MODE_BIT];
                    trig_lvl_o   <= data_i[CTL_TRIG_LSB +: 2];
                end
            end
        end
    end

    // R3
    rx_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clr_o |-> $past(wr_i && data_i[CTL_EN_BIT]));

    // R3
    tx_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clr_o |-> $past(wr_i && data_i[CTL_EN_BIT]));

    // R2
    hold_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !data_i[CTL_EN_BIT]) |=>
            (!fifo_en_o && !rx_clr_o && !tx_clr_o
             && $stable(mode_multi_o) && $stable(trig_lvl_o)));
endmodule

// File: rtl/uart_dma_rx_fsm.sv
module uart_dma_rx_fsm
    import uart_dma_req_pkg::*;
#(
    parameter int unsigned CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          multi_i,
    input  logic [CW-1:0] count_i,
    input  logic          trig_i,
    input  logic          timeout_i,
    output logic          draining_o
);
    rx_state_e state_q, state_d;
    logic      empty;

    assign empty = (count_i == '0);

    always_comb begin
        state_d = state_q;
        if (!multi_i) begin
            state_d = RX_IDLE;
        end else begin
            unique case (state_q)
                RX_IDLE:  if (!empty && (trig_i || timeout_i)) state_d = RX_DRAIN;
                RX_DRAIN: if (empty) state_d = RX_IDLE;
                default:  state_d = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        draining_o = (state_q == RX_DRAIN);
    end

    // R6
    enter_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (multi_i && state_q == RX_IDLE && (trig_i || timeout_i) && !empty)
            |=> state_q == RX_DRAIN);

    // R6
    leave_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_DRAIN && empty) |=> state_q == RX_IDLE);

    // R7
    empty_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_IDLE && empty) |=> state_q == RX_IDLE);
endmodule

// File: rtl/uart_dma_req.sv
module uart_dma_req
    import uart_dma_req_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic [7:0]    ctl_data,
    input  logic [CW-1:0] rx_count,
    input  logic          rx_trig_hit,
    input  logic          rx_timeout,
    input  logic [CW-1:0] tx_count,
    output logic          rx_req_n,
    output logic          tx_req_n,
    output logic          rx_clr,
    output logic          tx_clr,
    output logic          fifo_en,
    output logic [1:0]    rx_trig_lvl
);
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    logic mode_bit;
    logic multi;
    logic rx_drain;

    uart_dma_ctl_decode u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (ctl_wr),
        .data_i       (ctl_data),
        .fifo_en_o    (fifo_en),
        .mode_multi_o (mode_bit),
        .trig_lvl_o   (rx_trig_lvl),
        .rx_clr_o     (rx_clr),
        .tx_clr_o     (tx_clr)
    );

    assign multi = fifo_en && mode_bit;

    uart_dma_rx_fsm #(.CW(CW)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .multi_i    (multi),
        .count_i    (rx_count),
        .trig_i     (rx_trig_hit),
        .timeout_i  (rx_timeout),
        .draining_o (rx_drain)
    );

    always_comb begin
        if (multi) begin
            rx_req_n = !rx_drain;
            tx_req_n = (tx_count >= FULL_LVL);
        end else begin
            rx_req_n = (rx_count == '0);
            tx_req_n = (tx_count != '0);
        end
    end

    // R8
    tx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == FULL_LVL) |-> tx_req_n);

    // R6
    rx_start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (multi && $past(multi) && $fell(rx_req_n)) |-> $past(rx_trig_hit || rx_timeout));
endmodule

// File: tb/uart_dma_req_test.sv
module uart_dma_req_test;
    localparam int DEPTH = 16;
    localparam int CW    = 5;

    typedef struct packed {
        logic          wr;
        logic [7:0]    data;
        logic [CW-1:0] rxc;
        logic          trig;
        logic          tmo;
        logic [CW-1:0] txc;
        logic          e_rx_n;
        logic          e_tx_n;
        logic          e_rclr;
        logic          e_tclr;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h00, 5'd0,  1'b0, 1'b0, 5'd0,  1'b1, 1'b0, 1'b0, 1'b0}, // R4 R5 off
        '{1'b0, 8'h00, 5'd3,  1'b0, 1'b0, 5'd1,  1'b0, 1'b1, 1'b0, 1'b0}, // R4 R5
        '{1'b1, 8'h01, 5'd0,  1'b0, 1'b0, 5'd0,  1'b1, 1'b0, 1'b1, 1'b1}, // R3 first enable
        '{1'b1, 8'h39, 5'd2,  1'b0, 1'b0, 5'd5,  1'b1, 1'b0, 1'b0, 1'b0}, // R1 block, bits5:4 set
        '{1'b0, 8'h00, 5'd5,  1'b1, 1'b0, 5'd16, 1'b0, 1'b1, 1'b0, 1'b0}, // R6 R8 full
        '{1'b0, 8'h00, 5'd3,  1'b0, 1'b0, 5'd15, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 hold R8
        '{1'b0, 8'h00, 5'd0,  1'b0, 1'b0, 5'd15, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 drained
        '{1'b0, 8'h00, 5'd2,  1'b0, 1'b1, 5'd0,  1'b0, 1'b0, 1'b0, 1'b0}, // R6 timeout
        '{1'b0, 8'h00, 5'd1,  1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 1'b0}, // R6 hold
        '{1'b1, 8'h08, 5'd1,  1'b0, 1'b0, 5'd16, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 disable
        '{1'b1, 8'h0F, 5'd1,  1'b0, 1'b0, 5'd0,  1'b1, 1'b0, 1'b1, 1'b1}, // R3 R1 re-enable
        '{1'b1, 8'h03, 5'd4,  1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 1'b0}, // R3 rx clear
        '{1'b1, 8'h05, 5'd0,  1'b0, 1'b0, 5'd2,  1'b1, 1'b1, 1'b0, 1'b1}, // R3 tx clear
        '{1'b1, 8'h01, 5'd0,  1'b0, 1'b0, 5'd0,  1'b1, 1'b0, 1'b0, 1'b0}  // R3 none
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_wr = 1'b0;
    logic [7:0]    ctl_data = 8'h00;
    logic [CW-1:0] rx_count = '0;
    logic          rx_trig_hit = 1'b0;
    logic          rx_timeout = 1'b0;
    logic [CW-1:0] tx_count = '0;
    logic          rx_req_n, tx_req_n, rx_clr, tx_clr, fifo_en;
    logic [1:0]    rx_trig_lvl;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    uart_dma_req #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
        .rx_count(rx_count), .rx_trig_hit(rx_trig_hit), .rx_timeout(rx_timeout),
        .tx_count(tx_count), .rx_req_n(rx_req_n), .tx_req_n(tx_req_n),
        .rx_clr(rx_clr), .tx_clr(tx_clr), .fifo_en(fifo_en), .rx_trig_lvl(rx_trig_lvl)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic [7:0] d, input logic [CW-1:0] rc,
                        input logic tg, input logic to, input logic [CW-1:0] tc);
        @(negedge clk);
        ctl_wr = wr; ctl_data = d; rx_count = rc;
        rx_trig_hit = tg; rx_timeout = to; tx_count = tc;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        check("R9 fifo_en", 8'(fifo_en), 8'h0);
        check("R9 trig_lvl", 8'(rx_trig_lvl), 8'h0);
        check("R9 clears", {6'b0, rx_clr, tx_clr}, 8'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].wr, VEC[i].data, VEC[i].rxc, VEC[i].trig, VEC[i].tmo, VEC[i].txc);
            check($sformatf("vec%0d rx_req_n R4/R6", i), 8'(rx_req_n), 8'(VEC[i].e_rx_n));
            check($sformatf("vec%0d tx_req_n R5/R8", i), 8'(tx_req_n), 8'(VEC[i].e_tx_n));
            check($sformatf("vec%0d rx_clr R3", i), 8'(rx_clr), 8'(VEC[i].e_rclr));
            check($sformatf("vec%0d tx_clr R3", i), 8'(tx_clr), 8'(VEC[i].e_tclr));
        end

        // R7 trigger with empty buffer in block policy
        step(1'b1, 8'h09, 5'd0, 1'b0, 1'b0, 5'd0);
        step(1'b0, 8'h00, 5'd0, 1'b1, 1'b1, 5'd0);
        check("R7 no start on empty", 8'(rx_req_n), 8'h1);
        step(1'b0, 8'h00, 5'd2, 1'b0, 1'b0, 5'd0);
        check("R7 still idle", 8'(rx_req_n), 8'h1);

        // R2 disabling write while draining falls back to per-byte
        step(1'b0, 8'h00, 5'd2, 1'b1, 1'b0, 5'd0);
        check("R6 drain start", 8'(rx_req_n), 8'h0);
        step(1'b1, 8'h08, 5'd0, 1'b0, 1'b0, 5'd0);
        check("R2 per-byte when off", 8'(rx_req_n), 8'h1);

        // R3 back-to-back clear writes, one pulse each
        step(1'b1, 8'h03, 5'd0, 1'b0, 1'b0, 5'd0);
        check("R3 first-on rx", 8'(rx_clr), 8'h1);
        check("R3 first-on tx", 8'(tx_clr), 8'h1);
        step(1'b1, 8'h03, 5'd0, 1'b0, 1'b0, 5'd0);
        check("R3 second rx", 8'(rx_clr), 8'h1);
        check("R3 second tx", 8'(tx_clr), 8'h0);
        step(1'b0, 8'h00, 5'd0, 1'b0, 1'b0, 5'd0);
        check("R3 pulse ends", 8'(rx_clr), 8'h0);

        // R1 trigger field, R2 kept on disable
        step(1'b1, 8'hC1, 5'd0, 1'b0, 1'b0, 5'd0);
        check("R1 trig_lvl", 8'(rx_trig_lvl), 8'h3);
        check("R1 fifo_en", 8'(fifo_en), 8'h1);
        step(1'b1, 8'h40, 5'd0, 1'b0, 1'b0, 5'd0);
        check("R2 trig_lvl kept", 8'(rx_trig_lvl), 8'h3);
        check("R2 fifo_en off", 8'(fifo_en), 8'h0);
        check("R2 no clear", {6'b0, rx_clr, tx_clr}, 8'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule